// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether an incoming frame is accepted by a 64-bit hash table. The 48-bit destination address is folded into a 6-bit index, and that index selects one bit of the table. The result is then reported as a unicast hit or a multicast hit. Which of the two applies depends on the group bit of the address and on two enable inputs.

The address can reach the filter in two ways. It can be loaded as a 48-bit word with a one-cycle load strobe. It can also be shifted in one bit per cycle, in the order the bits arrive on the wire, with a marker on the final bit. The table is held in two 32-bit words. Software writes them and reads them back through a simple register port.

The result is registered. It appears on the clock after the lookup and stays there until the next lookup. Exact address compare, broadcast handling and promiscuous acceptance belong to other logic.

Top module: `dah_filter`

## Requirements
- R1: The table is written through `reg_wr`/`reg_sel`/`reg_wdata`. `reg_sel`=0 holds table bits 31:0 and `reg_sel`=1 holds table bits 63:32. `reg_rdata` returns the word chosen by `reg_sel`, and both words are zero after reset.
- R2: Bit n of the hash index, for n = 0 to 5, is the XOR of address bits n, n+6, n+12, ..., n+42. The index of the last lookup is shown on `hash_idx`.
- R3: `mc_match` is 1 after a lookup only if `mc_en` was 1, address bit 0 was 1 and the indexed table bit was 1. Otherwise it is 0.
- R4: `uc_match` is 1 after a lookup only if `uc_en` was 1, address bit 0 was 0 and the indexed table bit was 1. Otherwise it is 0.
- R5: With every table bit set and `mc_en`=1, every address with bit 0 set gives `mc_match`=1.
- R6: In serial mode, the first bit shifted in is address bit 0. Bytes arrive least significant bit first, so address bit i is byte i/8, bit i mod 8. A lookup happens on the cycle in which `ser_en` and `ser_last` are both 1, and it uses that bit together with the 47 bits before it. On `addr_word`, bit i is address bit i.
- R7: Results appear exactly one clock after the lookup cycle. They hold unchanged, whatever the other inputs do, until the next lookup.
- R8: A table write in the same cycle as a lookup does not affect that lookup. It affects only later lookups.
- R9: After reset, `uc_match`, `mc_match` and `hash_idx` are 0.
- R10: If `addr_load` and a serial final bit fall in the same cycle, the word on `addr_word` is used for the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_word | input | 48 | Parallel destination address, bit 0 = group bit |
| addr_load | input | 1 | Lookup strobe for `addr_word` |
| ser_bit | input | 1 | Serial address bit |
| ser_en | input | 1 | `ser_bit` is valid this cycle |
| ser_last | input | 1 | With `ser_en`, marks the 48th bit and triggers a lookup |
| reg_wr | input | 1 | Table word write enable |
| reg_sel | input | 1 | Table word select: 0 = bits 31:0, 1 = bits 63:32 |
| reg_wdata | input | 32 | Table write data |
| reg_rdata | output | 32 | Selected table word |
| uc_en | input | 1 | Unicast hash match enable |
| mc_en | input | 1 | Multicast hash match enable |
| hash_idx | output | 6 | Index of the last lookup |
| uc_match | output | 1 | Unicast hash hit |
| mc_match | output | 1 | Multicast hash hit |

## Verification
Every lookup result is due exactly one clock after the strobe cycle: the parallel load or the serial final bit. The bench drives that strobe on a falling edge. It then samples `hash_idx`, `uc_match` and `mc_match` at the falling edge that follows the capturing rising edge. Register read data is combinational from the stored words. It is therefore sampled one falling edge after the write.

To check that results hold, the bench changes the address, the enables and the table without a strobe for several cycles, then samples again. For the same-cycle write case, the first result must reflect the old table and the next lookup the new one.

// File: rtl/dah_pkg.sv
// Package dah_pkg
// Shared sizes for the destination address hash filter.
// Assumes the table width is a power of two equal to 2**IDX_W.
package dah_pkg;
    localparam int ADDR_W = 48;   // destination address width
    localparam int IDX_W  = 6;    // hash index width
    localparam int TBL_W  = 64;   // hash table width
    localparam int REG_W  = 32;   // register port word width
endpackage

// File: rtl/dah_fold.sv
// Module dah_fold
// Folds an address into a hash index. Index bit n is the XOR of every
// IDX_W-th address bit, starting at bit n. Purely combinational.
// Assumes ADDR_W >= IDX_W.
module dah_fold #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int TERMS = (ADDR_W + IDX_W - 1) / IDX_W;

    for (genvar n = 0; n < IDX_W; n++) begin : g_bit
        // XOR reduce the address bits that land on index bit n
        always_comb begin
            idx[n] = 1'b0;
            for (int k = 0; k < TERMS; k++) begin
                if (n + k * IDX_W < ADDR_W) idx[n] = idx[n] ^ addr[n + k * IDX_W];
            end
        end
    end
endmodule

// File: rtl/dah_table.sv
// Module dah_table
// Holds the hash table as REG_W-bit words written through a register port.
// Word w holds table bits w*REG_W+REG_W-1 : w*REG_W. Read data is combinational.
// Assumes TBL_W is a multiple of REG_W and that the word count is a power of two.
module dah_table #(
    parameter int TBL_W = 64,
    parameter int REG_W = 32,
    localparam int NWORDS = TBL_W / REG_W,
    localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [TBL_W-1:0] table_bits
);
    logic [REG_W-1:0] words [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        // Store one table word; cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n)                              words[w] <= '0;
            else if (wr && (int'(sel) == w))         words[w] <= wdata;
        end
        assign table_bits[w*REG_W +: REG_W] = words[w];
    end

    // Return the selected word to the register port
    always_comb begin
        rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (int'(sel) == w) rdata = words[w];
        end
    end
endmodule

// File: rtl/dah_serin.sv
// Module dah_serin
// Assembles a bit-serial address. The first bit received becomes bit 0.
// On a valid bit flagged as last, the full address (including that bit)
// is presented combinationally together with a done pulse.
// Assumes the sender delivers exactly ADDR_W bits per address.
module dah_serin #(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_en,
    input  logic              bit_last,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    logic [ADDR_W-1:0] shreg;

    // Shift new bits in at the top so that the oldest settles at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)      shreg <= '0;
        else if (bit_en) shreg <= {bit_in, shreg[ADDR_W-1:1]};
    end

    assign addr = {bit_in, shreg[ADDR_W-1:1]};
    assign done = bit_en && bit_last;
endmodule

// File: rtl/dah_filter.sv
// Module dah_filter (top)
// Destination address hash filter. A lookup happens on a parallel load
// strobe or on the final serial bit; the parallel load wins if both occur.
// Address bit 0 is the group bit. The result registers one clock later and
// holds until the next lookup. The table value sampled is the one stored
// before any write in the same cycle.
module dah_filter #(
    parameter int ADDR_W = dah_pkg::ADDR_W,
    parameter int IDX_W  = dah_pkg::IDX_W,
    parameter int REG_W  = dah_pkg::REG_W,
    localparam int TBL_W = 1 << IDX_W,
    localparam int SEL_W = (TBL_W / REG_W > 1) ? $clog2(TBL_W / REG_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_word,
    input  logic              addr_load,
    input  logic              ser_bit,
    input  logic              ser_en,
    input  logic              ser_last,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              uc_en,
    input  logic              mc_en,
    output logic [IDX_W-1:0]  hash_idx,
    output logic              uc_match,
    output logic              mc_match
);
    logic [TBL_W-1:0]  table_bits;
    logic [ADDR_W-1:0] ser_addr;
    logic              ser_done;
    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  look_idx;
    logic              look_go;
    logic              tbl_hit;

    dah_table #(.TBL_W(TBL_W), .REG_W(REG_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .table_bits(table_bits)
    );

    dah_serin #(.ADDR_W(ADDR_W)) u_serin (
        .clk(clk), .rst_n(rst_n), .bit_in(ser_bit), .bit_en(ser_en),
        .bit_last(ser_last), .addr(ser_addr), .done(ser_done)
    );

    // Pick the address source; the parallel word has priority
    always_comb begin
        look_addr = addr_load ? addr_word : ser_addr;
        look_go   = addr_load || ser_done;
    end

    dah_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold (
        .addr(look_addr), .idx(look_idx)
    );

    assign tbl_hit = table_bits[look_idx];

    // Register the lookup result and hold it until the next lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_idx <= '0;
            uc_match <= 1'b0;
            mc_match <= 1'b0;
        end else if (look_go) begin
            hash_idx <= look_idx;
            uc_match <= uc_en && !look_addr[0] && tbl_hit;
            mc_match <= mc_en &&  look_addr[0] && tbl_hit;
        end
    end
endmodule

// File: rtl/dah_filter_chk.sv
// Module dah_filter_chk
// Port-level temporal checks for dah_filter, attached by bind.
module dah_filter_chk #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_word,
    input logic              addr_load,
    input logic              ser_en,
    input logic              ser_last,
    input logic              uc_en,
    input logic              mc_en,
    input logic [IDX_W-1:0]  hash_idx,
    input logic              uc_match,
    input logic              mc_match
);
    logic any_look;
    assign any_look = addr_load || (ser_en && ser_last);

    // R3
    grp0_no_mc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && !addr_word[0]) |=> !mc_match);
    // R3
    mc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_look && !mc_en) |=> !mc_match);
    // R4
    grp1_no_uc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && addr_word[0]) |=> !uc_match);
    // R4
    uc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_look && !uc_en) |=> !uc_match);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_look |=> ($stable(hash_idx) && $stable(uc_match) && $stable(mc_match)));
endmodule

bind dah_filter dah_filter_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_word(addr_word), .addr_load(addr_load),
    .ser_en(ser_en), .ser_last(ser_last), .uc_en(uc_en), .mc_en(mc_en),
    .hash_idx(hash_idx), .uc_match(uc_match), .mc_match(mc_match)
);

// File: tb/dah_filter_test.sv
module dah_filter_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [47:0] addr_word = '0;
    logic        addr_load = 0, ser_bit = 0, ser_en = 0, ser_last = 0;
    logic        reg_wr = 0, reg_sel = 0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        uc_en = 0, mc_en = 0;
    logic [5:0]  hash_idx;
    logic        uc_match, mc_match;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [63:0] tbl = '0;   // bench model of the table

    always #10 clk = ~clk;   // 50 MHz

    dah_filter uut (
        .clk(clk), .rst_n(rst_n), .addr_word(addr_word), .addr_load(addr_load),
        .ser_bit(ser_bit), .ser_en(ser_en), .ser_last(ser_last),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .uc_en(uc_en), .mc_en(mc_en), .hash_idx(hash_idx),
        .uc_match(uc_match), .mc_match(mc_match)
    );

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [5:0] r = '0;
        for (int i = 0; i < 48; i++) r[i % 6] = r[i % 6] ^ a[i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (sel) tbl[63:32] = d; else tbl[31:0] = d;
    endtask

    task automatic par_look(input logic [47:0] a);
        @(negedge clk);
        addr_word = a; addr_load = 1;
        @(negedge clk);
        addr_load = 0;
    endtask

    task automatic ser_look(input logic [47:0] a);
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            ser_en = 1; ser_bit = a[i]; ser_last = (i == 47);
        end
        @(negedge clk);
        ser_en = 0; ser_last = 0;
    endtask

    task automatic chk_result(input string req, input logic [47:0] a, input logic [63:0] t);
        logic hit;
        hit = t[ref_idx(a)];
        chk({req, " idx"}, 64'(hash_idx), 64'(ref_idx(a)));
        chk({req, " uc"}, 64'(uc_match), 64'(uc_en && !a[0] && hit));
        chk({req, " mc"}, 64'(mc_match), 64'(mc_en && a[0] && hit));
    endtask

    // address with a chosen index and group bit, other bits from a seed
    function automatic logic [47:0] mk_addr(input logic [47:0] seed, input logic [5:0] idx, input logic g);
        logic [47:0] a = seed;
        a[0] = g;
        a[47:42] = a[47:42] ^ (ref_idx(a) ^ idx);
        return a;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] a, b, seed;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 / R1 reset state
        chk("R9 uc", 64'(uc_match), 0);
        chk("R9 mc", 64'(mc_match), 0);
        chk("R9 idx", 64'(hash_idx), 0);
        reg_sel = 0; #1 chk("R1 lo reset", 64'(reg_rdata), 0);
        reg_sel = 1; #1 chk("R1 hi reset", 64'(reg_rdata), 0);

        // R1 write/readback each word
        wr_word(0, 32'hA5A5_0F0F);
        wr_word(1, 32'h1234_5678);
        reg_sel = 0; #1 chk("R1 lo", 64'(reg_rdata), 64'hA5A5_0F0F);
        reg_sel = 1; #1 chk("R1 hi", 64'(reg_rdata), 64'h1234_5678);

        // R2 R3 R4: sweep every index, one-hot table, all enable/group combos
        seed = 48'h3C5A_9617_E2B4;
        for (int ix = 0; ix < 64; ix++) begin
            logic [63:0] oh;
            oh = 64'd1 << ix;
            wr_word(0, oh[31:0]);
            wr_word(1, oh[63:32]);
            for (int c = 0; c < 8; c++) begin
                uc_en = c[0]; mc_en = c[1];
                a = mk_addr(seed, 6'(ix), c[2]);
                par_look(a);
                chk_result("R2R3R4 hit", a, tbl);
                a = mk_addr(seed, 6'(ix + 1), c[2]);
                par_look(a);
                chk_result("R2R3R4 miss", a, tbl);
            end
            seed = {seed[46:0], seed[47] ^ seed[41]} + 48'h1_0000_0345;
        end

        // R5 all-ones table with multicast enable
        wr_word(0, '1); wr_word(1, '1);
        uc_en = 0; mc_en = 1;
        for (int j = 0; j < 64; j++) begin
            a = mk_addr(48'h0F1E_2D3C_4B5A ^ (48'(j) << 8), 6'(j), 1'b1);
            par_look(a);
            chk("R5 mc all", 64'(mc_match), 1);
        end

        // R6 serial input, byte bits least significant first
        wr_word(0, 32'h0F0F_3C3C); wr_word(1, 32'h9696_C3C3);
        uc_en = 1; mc_en = 1;
        for (int j = 0; j < 16; j++) begin
            a = 48'h0123_4567_89AB ^ (48'(j) * 48'h1357_9BDF_0247);
            ser_look(a);
            chk_result("R6 serial", a, tbl);
        end
        a = 48'hFE00_0000_0001;   // group bit first, high byte last
        ser_look(a);
        chk_result("R6 serial order", a, tbl);

        // R10 parallel word wins over simultaneous serial final bit
        a = 48'h0000_0000_0003; b = 48'h8000_0000_0000;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            ser_en = 1; ser_bit = b[i]; ser_last = (i == 47);
            if (i == 47) begin addr_word = a; addr_load = 1; end
        end
        @(negedge clk);
        ser_en = 0; ser_last = 0; addr_load = 0;
        chk_result("R10 priority", a, tbl);

        // R7 hold: change inputs without lookup
        a = mk_addr(48'h5555_AAAA_3333, 6'd5, 1'b1);
        par_look(a);
        chk_result("R7 first", a, tbl);
        addr_word = ~a; uc_en = 0; mc_en = 0;
        @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0;
        @(negedge clk); reg_wr = 0; tbl[31:0] = 32'h0;
        repeat (3) @(negedge clk);
        chk("R7 hold mc", 64'(mc_match), 64'(tbl[5] | 1'b1));
        chk("R7 hold idx", 64'(hash_idx), 5);

        // R8 write in same cycle as lookup uses the old table
        wr_word(0, 32'h0000_0000); wr_word(1, 32'h0000_0000);
        uc_en = 1; mc_en = 1;
        a = mk_addr(48'h1111_2222_3333, 6'd9, 1'b0);
        @(negedge clk);
        addr_word = a; addr_load = 1;
        reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0000_0200;
        @(negedge clk);
        addr_load = 0; reg_wr = 0;
        chk("R8 old table", 64'(uc_match), 0);
        par_look(a);
        chk("R8 new table", 64'(uc_match), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule